// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block commits a trap for a hart that has machine, supervisor and user privilege levels. Each cycle it may accept one request. A request carries an interrupt flag, a kind (ordinary trap, breakpoint or environment call), a code, a trap value and the PC of the instruction that trapped. From the two delegation registers and the current privilege, the block picks machine or supervisor as the destination. It then fills that level's exception-PC, cause and trap-value registers and pushes the status interrupt-enable stack. It also computes where execution resumes from the level's trap-vector register.

One clock edge after the request, the block presents the redirect PC with a one-cycle branch strobe and the new privilege mode. A small CSR port, with one select shared by reads and writes, reaches the delegation, vector, exception-PC, cause, trap-value and status registers and the current privilege. The CSR read data is combinational.

Top module: `trap_entry`

## Requirements
- R1: After reset the privilege is machine (3), the strobe is low, and every register on the CSR port reads 0.
- R2: An accepted request (`trap_valid`=1 at a clock edge) updates all registers at that edge. `redirect_valid` is high for exactly the following cycle, with `redirect_pc` and `priv_mode` valid in that cycle. A cycle with no request leaves the strobe low in the next cycle.
- R3: An exception (`trap_irq`=0) goes to supervisor (1) only if the current privilege is not machine and the exception-delegation bit indexed by its code is set. Otherwise it goes to machine (3).
- R4: An interrupt goes to supervisor only if the current privilege is not machine and the interrupt-delegation bit indexed by its code is set. Otherwise it goes to machine. A trap never lowers the privilege from machine.
- R5: With `v` the destination's vector register, the redirect PC is `v` with bits [1:0] cleared. When `v[1:0]`==1, 4 times the code is added to that.
- R6: The destination's exception-PC register takes `trap_pc`, its trap-value register takes the trap value, and its cause register takes the code. For an interrupt, bit XLEN-1 of the cause is also set.
- R7: A trap to machine sets MPP (status[12:11]) to the old privilege and MPIE (status[7]) to the old MIE (status[3]), then clears MIE.
- R8: A trap to supervisor sets SPP (status[8]) to bit 0 of the old privilege and SPIE (status[5]) to the old SIE (status[1]), then clears SIE.
- R9: Writes to the exception-delegation register are masked with 0xB3FF, so code 11 can never be delegated.
- R10: `trap_kind`=1 (breakpoint) uses code 3. `trap_kind`=2 (environment call) uses code 8 + current privilege (8 from user, 9 from supervisor, 11 from machine). Both record a trap value of 0. Kinds 0 and 3 use `trap_code` and `trap_value`.
- R11: A CSR write in the same cycle as an accepted request is dropped. A write of the value 2 to the privilege select is dropped.
- R12: CSR selects are 0 exception delegation, 1 interrupt delegation, 2 machine vector, 3 supervisor vector, 4/5/6 machine exception-PC/cause/trap-value, 7/8/9 supervisor exception-PC/cause/trap-value, 10 status, 11 privilege. Unused selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request accepted this cycle |
| trap_irq | input | 1 | Request is an interrupt |
| trap_kind | input | 2 | 0/3 ordinary, 1 breakpoint, 2 environment call |
| trap_code | input | $clog2(XLEN) | Exception or interrupt code for ordinary traps |
| trap_value | input | XLEN | Trap value for ordinary traps |
| trap_pc | input | XLEN | PC of the trapping instruction |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 4 | CSR select for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for `csr_sel` |
| redirect_valid | output | 1 | One-cycle branch strobe |
| redirect_pc | output | XLEN | Handler address |
| priv_mode | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |

## Verification
The delegation decision is tried from all three privileges, with delegation bits both set and clear. These patterns separate the "below machine" gate from the bit lookup, and the exception register from the interrupt register. Direct and vectored modes appear at both levels: a vectored target shows that the effective code, not the raw input, is scaled, and a direct target shows the mode bits are stripped. Environment calls from each privilege and a breakpoint confirm the substituted codes and the zeroed trap value. Codes 11 and 14 expose the write mask. Separate cases check each status stack, a CSR write that collides with a trap, and a write of the reserved privilege value.

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int XLEN  = 32,
  parameter int SEL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trap_valid,
  input  logic                     trap_irq,
  input  logic [1:0]               trap_kind,
  input  logic [$clog2(XLEN)-1:0]  trap_code,
  input  logic [XLEN-1:0]          trap_value,
  input  logic [XLEN-1:0]          trap_pc,
  input  logic                     csr_we,
  input  logic [SEL_W-1:0]         csr_sel,
  input  logic [XLEN-1:0]          csr_wdata,
  output logic [XLEN-1:0]          csr_rdata,
  output logic                     redirect_valid,
  output logic [XLEN-1:0]          redirect_pc,
  output logic [1:0]               priv_mode
);
  localparam int CW = $clog2(XLEN);
  localparam logic [XLEN-1:0] EDELEG_MASK = XLEN'(32'hB3FF);
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] PRIV_S = 2'd1;

  logic [XLEN-1:0] edeleg, ideleg, mvec, svec;
  logic [XLEN-1:0] mepc, mcause, mtval, sepc, scause, stval;
  logic            st_mie, st_sie, st_mpie, st_spie, st_spp;
  logic [1:0]      st_mpp;

  logic [CW-1:0]   eff_code;
  logic            to_s;
  logic [XLEN-1:0] vec, base, target, cause_val, tval_val, status_word;

  assign eff_code  = (trap_kind == 2'd1) ? CW'(3) :
                     (trap_kind == 2'd2) ? CW'(8) + CW'(priv_mode) : trap_code;
  assign to_s      = (priv_mode != PRIV_M) &&
                     (trap_irq ? ideleg[eff_code] : edeleg[eff_code]);
  assign vec       = to_s ? svec : mvec;
  assign base      = {vec[XLEN-1:2], 2'b00};
  assign target    = (vec[1:0] == 2'd1) ? base + (XLEN'(eff_code) << 2) : base;
  assign cause_val = XLEN'(eff_code) | ({{(XLEN-1){1'b0}}, trap_irq} << (XLEN-1));
  assign tval_val  = (trap_kind == 2'd1 || trap_kind == 2'd2) ? '0 : trap_value;

  assign status_word = (XLEN'(st_mpp) << 11) | (XLEN'(st_spp) << 8) |
                       (XLEN'(st_mpie) << 7) | (XLEN'(st_spie) << 5) |
                       (XLEN'(st_mie) << 3)  | (XLEN'(st_sie) << 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edeleg <= '0; ideleg <= '0; mvec <= '0; svec <= '0;
      mepc <= '0; mcause <= '0; mtval <= '0;
      sepc <= '0; scause <= '0; stval <= '0;
      st_mie <= 1'b0; st_sie <= 1'b0; st_mpie <= 1'b0; st_spie <= 1'b0;
      st_spp <= 1'b0; st_mpp <= 2'd0;
      priv_mode <= PRIV_M;
      redirect_valid <= 1'b0;
      redirect_pc <= '0;
    end else begin
      redirect_valid <= trap_valid;
      if (trap_valid) begin
        redirect_pc <= target;
        if (to_s) begin
          sepc    <= trap_pc;
          scause  <= cause_val;
          stval   <= tval_val;
          st_spp  <= priv_mode[0];
          st_spie <= st_sie;
          st_sie  <= 1'b0;
          priv_mode <= PRIV_S;
        end else begin
          mepc    <= trap_pc;
          mcause  <= cause_val;
          mtval   <= tval_val;
          st_mpp  <= priv_mode;
          st_mpie <= st_mie;
          st_mie  <= 1'b0;
          priv_mode <= PRIV_M;
        end
      end else if (csr_we) begin
        case (csr_sel)
          SEL_W'(0):  edeleg <= csr_wdata & EDELEG_MASK;
          SEL_W'(1):  ideleg <= csr_wdata;
          SEL_W'(2):  mvec   <= csr_wdata;
          SEL_W'(3):  svec   <= csr_wdata;
          SEL_W'(4):  mepc   <= csr_wdata;
          SEL_W'(5):  mcause <= csr_wdata;
          SEL_W'(6):  mtval  <= csr_wdata;
          SEL_W'(7):  sepc   <= csr_wdata;
          SEL_W'(8):  scause <= csr_wdata;
          SEL_W'(9):  stval  <= csr_wdata;
          SEL_W'(10): begin
            st_mpp  <= csr_wdata[12:11];
            st_spp  <= csr_wdata[8];
            st_mpie <= csr_wdata[7];
            st_spie <= csr_wdata[5];
            st_mie  <= csr_wdata[3];
            st_sie  <= csr_wdata[1];
          end
          SEL_W'(11): if (csr_wdata[1:0] != 2'd2) priv_mode <= csr_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (csr_sel)
      SEL_W'(0):  csr_rdata = edeleg;
      SEL_W'(1):  csr_rdata = ideleg;
      SEL_W'(2):  csr_rdata = mvec;
      SEL_W'(3):  csr_rdata = svec;
      SEL_W'(4):  csr_rdata = mepc;
      SEL_W'(5):  csr_rdata = mcause;
      SEL_W'(6):  csr_rdata = mtval;
      SEL_W'(7):  csr_rdata = sepc;
      SEL_W'(8):  csr_rdata = scause;
      SEL_W'(9):  csr_rdata = stval;
      SEL_W'(10): csr_rdata = status_word;
      SEL_W'(11): csr_rdata = XLEN'(priv_mode);
      default:    csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [1:0]      priv_mode,
  input logic            st_mie,
  input logic            st_sie
);
  AST_STROBE_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> redirect_valid);                                    // R2
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !redirect_valid);                                  // R2
  AST_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && priv_mode == 2'd3) |=> priv_mode == 2'd3);          // R4
  AST_M_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && priv_mode == 2'd3) |-> !st_mie);                // R7
  AST_S_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && priv_mode == 2'd1) |-> !st_sie);                // R8
  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_pc[1:0] == 2'b00);                     // R5
  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode != 2'd2);                                                // R11
endmodule

bind trap_entry trap_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_trap_entry.sv
module sim_trap_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0, trap_irq = 1'b0;
  logic [1:0]  trap_kind = 2'd0;
  logic [4:0]  trap_code = '0;
  logic [31:0] trap_value = '0, trap_pc = '0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic [1:0]  priv_mode;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  trap_entry u0 (.*);

  typedef struct packed {
    logic [1:0]  priv;
    logic        vm;
    logic [31:0] edeleg, ideleg;
    logic        irq;
    logic [1:0]  kind;
    logic [4:0]  code;
    logic [31:0] tval, pc;
    logic [1:0]  xpriv;
    logic [31:0] xpc, xcause, xtval;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd3,1'b0,32'hFFFF,32'h0, 1'b0,2'd0,5'd2, 32'hDEAD,32'h1000, 2'd3,32'h100,32'h2,32'hDEAD},
    '{2'd0,1'b0,32'hFFFF,32'h0, 1'b0,2'd0,5'd2, 32'h55,  32'h2000, 2'd1,32'h300,32'h2,32'h55},
    '{2'd0,1'b1,32'h0,   32'h0, 1'b0,2'd0,5'd2, 32'h66,  32'h2004, 2'd3,32'h208,32'h2,32'h66},
    '{2'd1,1'b1,32'h0,   32'h20,1'b1,2'd0,5'd5, 32'h77,  32'h2008, 2'd1,32'h414,32'h80000005,32'h77},
    '{2'd1,1'b0,32'h0,   32'h20,1'b1,2'd0,5'd7, 32'h0,   32'h200C, 2'd3,32'h100,32'h80000007,32'h0},
    '{2'd3,1'b1,32'h0,   32'h20,1'b1,2'd0,5'd5, 32'h0,   32'h2010, 2'd3,32'h214,32'h80000005,32'h0},
    '{2'd0,1'b0,32'hFFFF,32'h0, 1'b0,2'd2,5'd31,32'h99,  32'h2014, 2'd1,32'h300,32'h8,32'h0},
    '{2'd1,1'b1,32'hFFFF,32'h0, 1'b0,2'd2,5'd0, 32'h99,  32'h2018, 2'd1,32'h424,32'h9,32'h0},
    '{2'd3,1'b0,32'hFFFF,32'h0, 1'b0,2'd2,5'd0, 32'h99,  32'h201C, 2'd3,32'h100,32'hB,32'h0},
    '{2'd1,1'b1,32'h0,   32'h0, 1'b0,2'd1,5'd0, 32'hAA,  32'h2020, 2'd3,32'h20C,32'h3,32'h0},
    '{2'd1,1'b0,32'hFFFF,32'h0, 1'b0,2'd0,5'd11,32'hBB,  32'h2024, 2'd3,32'h100,32'hB,32'hBB},
    '{2'd0,1'b0,32'hFFFF,32'h0, 1'b0,2'd0,5'd14,32'hCC,  32'h2028, 2'd3,32'h100,32'hE,32'hCC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [31:0] d);
    csr_sel = sel;
    #1;
    d = csr_rdata;
  endtask

  task automatic trap(input logic irq, input logic [1:0] kind, input logic [4:0] code,
                      input logic [31:0] tv, input logic [31:0] pc, input logic collide);
    @(negedge clk);
    trap_valid = 1'b1; trap_irq = irq; trap_kind = kind; trap_code = code;
    trap_value = tv; trap_pc = pc;
    if (collide) begin csr_we = 1'b1; csr_sel = 4'd4; csr_wdata = 32'h1234; end
    @(negedge clk);
    trap_valid = 1'b0; trap_irq = 1'b0; trap_kind = 2'd0; csr_we = 1'b0;
  endtask

  task automatic setup(input logic [1:0] p, input logic vm, input logic [31:0] ed,
                       input logic [31:0] id);
    wr(4'd11, {30'd0, p});
    wr(4'd0, ed);
    wr(4'd1, id);
    wr(4'd2, vm ? 32'h201 : 32'h100);
    wr(4'd3, vm ? 32'h401 : 32'h300);
    wr(4'd10, 32'h0A);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobe", {31'd0, redirect_valid}, 32'd0);
    chk("R1 priv", {30'd0, priv_mode}, 32'd3);
    rd(4'd4, rv);  chk("R1 mepc", rv, 32'd0);
    rd(4'd10, rv); chk("R1 status", rv, 32'd0);
    rd(4'd0, rv);  chk("R1 edeleg", rv, 32'd0);

    // Table walk: R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      setup(TBL[i].priv, TBL[i].vm, TBL[i].edeleg, TBL[i].ideleg);
      trap(TBL[i].irq, TBL[i].kind, TBL[i].code, TBL[i].tval, TBL[i].pc, 1'b0);
      chk($sformatf("R2 strobe v%0d", i), {31'd0, redirect_valid}, 32'd1);
      chk($sformatf("R3/R4 priv v%0d", i), {30'd0, priv_mode}, {30'd0, TBL[i].xpriv});
      chk($sformatf("R5 target v%0d", i), redirect_pc, TBL[i].xpc);
      rd(TBL[i].xpriv == 2'd3 ? 4'd4 : 4'd7, rv);
      chk($sformatf("R6 epc v%0d", i), rv, TBL[i].pc);
      rd(TBL[i].xpriv == 2'd3 ? 4'd5 : 4'd8, rv);
      chk($sformatf("R6/R10 cause v%0d", i), rv, TBL[i].xcause);
      rd(TBL[i].xpriv == 2'd3 ? 4'd6 : 4'd9, rv);
      chk($sformatf("R6/R10 tval v%0d", i), rv, TBL[i].xtval);
    end

    // R2 strobe lasts one cycle
    @(negedge clk);
    chk("R2 strobe drop", {31'd0, redirect_valid}, 32'd0);

    // R9 delegation write mask
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, rv); chk("R9 mask", rv, 32'h0000_B3FF);

    // R7 machine stack: from supervisor, MIE=SIE=1
    setup(2'd1, 1'b0, 32'h0, 32'h0);
    trap(1'b0, 2'd0, 5'd2, 32'h0, 32'h3000, 1'b0);
    rd(4'd10, rv); chk("R7 status", rv, 32'h0000_0882);

    // R8 supervisor stack: from supervisor, MIE=SIE=1
    setup(2'd1, 1'b0, 32'hFFFF, 32'h0);
    trap(1'b0, 2'd0, 5'd2, 32'h0, 32'h3004, 1'b0);
    rd(4'd10, rv); chk("R8 status", rv, 32'h0000_0128);

    // R11 collision: write to mepc in the trap cycle is dropped
    setup(2'd3, 1'b0, 32'h0, 32'h0);
    trap(1'b0, 2'd0, 5'd4, 32'h1, 32'h3008, 1'b1);
    rd(4'd4, rv); chk("R11 collide mepc", rv, 32'h3008);

    // R11 reserved privilege write dropped, legal one taken
    wr(4'd11, 32'h2);
    chk("R11 priv 2 dropped", {30'd0, priv_mode}, 32'd3);
    wr(4'd11, 32'h0);
    chk("R11 priv 0 taken", {30'd0, priv_mode}, 32'd0);

    // R12 unused select reads 0, privilege select reads current mode
    rd(4'd13, rv); chk("R12 unused", rv, 32'd0);
    rd(4'd11, rv); chk("R12 priv read", rv, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule